// File: doc/BRIEF.md
# Dual-Rail Run-Expanding Packet Receiver

This block sits at the receiving end of a clockless two-wire serial link. One wire carries the data level and the other is a phase wire. Exactly one wire changes per ordinary symbol. The block samples both wires on the local system clock and treats every change it sees as one symbol. It then rebuilds a 32-bit packet, one cell per symbol.

The transmitter can also replace a run of identical bits with a compressed form:

1. Both wires change together, which forms a marker.
2. A 5-bit run length follows, most significant bit first.
3. A second marker closes the form.

On the closing marker the receiver fills the whole run of cells in a single clock cycle. A range-enable decoder drives every cell from the run's first index to its last index. When the last cell is written, the full packet appears on the output together with a one-cycle valid pulse.

Top module: `dr_run_rx`

## Requirements
- R1: Each wire passes through a two-flop synchroniser. A change on either synchronised wire, compared with its value one clock earlier, is one symbol strobe. A packet of 32 ordinary symbols therefore fills exactly 32 cells.
- R2: In count mode, a strobe with a change on one wire only stores one bit and advances the cell index by one. The stored bit equals the data wire's level after the change: the previous bit when the phase wire changed, the inverted bit when the data wire changed. The first bit of a packet lands in bit 0 of `pkt_data`.
- R3: A strobe where both wires change in the same sample is a marker. In count mode a marker stores nothing and starts length reception.
- R4: The next 5 strobes each carry one length bit, taken as the data wire level, most significant bit first. A closing marker then writes code+1 cells in one cycle. The run starts at the current index and takes the most recently stored bit. The run is clipped at cell 31, and the index moves to the cell after the run.
- R5: If the strobe after the 5 length bits is not a marker, `link_err` pulses for one cycle. No cell is written, the index is unchanged, and count mode resumes.
- R6: The write that fills cell 31 updates `pkt_data` with all 32 cells and raises `pkt_valid` for exactly one cycle. The index returns to 0.
- R7: After reset, `pkt_data` is 0, `pkt_valid` and `link_err` are 0, and the receiver is in count mode at index 0 with a stored bit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_in | input | 1 | Data wire, asynchronous |
| p_in | input | 1 | Phase wire, asynchronous |
| pkt_data | output | 32 | Last completed packet, cell 0 in bit 0 |
| pkt_valid | output | 1 | One-cycle pulse when `pkt_data` is updated |
| link_err | output | 1 | One-cycle pulse on a missing closing marker |

## Verification
The hardest situations to reach from the ports are runs whose end coincides with or overshoots cell 31, because they must also complete the packet. The bench sweeps every length code against run start positions near the front, middle and very end of the packet, so both clipping and exact fits occur. A separate sequence replaces the closing marker with a single-wire change and then finishes the packet. This shows at the output that the index did not move.

// File: rtl/dr_run_rx_pkg.sv
// Shared types for the run-expanding receiver.
package dr_run_rx_pkg;
    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_LEN   = 2'd1,
        ST_CLOSE = 2'd2
    } rx_state_e;
endpackage

// File: rtl/dr_edge_sync.sv
// Synchronises NW asynchronous wires with two flops each and flags a change
// when the synchronised level differs from its value one clock earlier.
// Assumes the wires change no faster than once every few clocks.
module dr_edge_sync #(
    parameter int NW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] wire_in,
    output logic [NW-1:0] level,
    output logic [NW-1:0] chg
);
    genvar g;
    generate
        for (g = 0; g < NW; g++) begin : g_wire
            logic ff1, ff2, prev;
            // two-flop synchroniser plus history flop
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ff1  <= 1'b0;
                    ff2  <= 1'b0;
                    prev <= 1'b0;
                end else begin
                    ff1  <= wire_in[g];
                    ff2  <= ff1;
                    prev <= ff2;
                end
            end
            assign level[g] = ff2;
            assign chg[g]   = ff2 ^ prev;
        end
    endgenerate
endmodule

// File: rtl/rx_seq_ctrl.sv
// Receiver sequencer: tracks count / length / close modes and the cell index.
// It turns each strobe into a single-cell write, a length bit, or a range write.
// Assumes PKT_W is a power of two, so a LEN_W-bit code spans 1..PKT_W cells.
module rx_seq_ctrl
    import dr_run_rx_pkg::*;
#(
    parameter int PKT_W = 32,
    parameter int IDX_W = $clog2(PKT_W),
    parameter int LEN_W = $clog2(PKT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             marker,
    input  logic             s_lvl,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_from,
    output logic [IDX_W-1:0] wr_till,
    output logic             wr_bit,
    output logic             pkt_done,
    output logic             link_err
);
    localparam int CW = $clog2(LEN_W + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_W - 1);

    rx_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] len_code;
    logic [CW-1:0]    len_cnt;
    logic             last_bit;
    logic [IDX_W:0]   run_sum;
    logic [IDX_W-1:0] run_till;

    // run end index, clipped at the last cell
    always_comb begin
        run_sum  = {1'b0, idx} + (IDX_W+1)'(len_code);
        run_till = (run_sum > (IDX_W+1)'(PKT_W - 1)) ? LAST : run_sum[IDX_W-1:0];
    end

    // write request towards the cell bank
    always_comb begin
        wr_en    = strobe && (((state == ST_COUNT) && !marker) ||
                              ((state == ST_CLOSE) && marker));
        wr_from  = idx;
        wr_till  = (state == ST_CLOSE) ? run_till : idx;
        wr_bit   = (state == ST_CLOSE) ? last_bit : s_lvl;
        pkt_done = wr_en && (wr_till == LAST);
    end

    // mode, index and length-code sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_COUNT;
            idx      <= '0;
            len_code <= '0;
            len_cnt  <= '0;
            last_bit <= 1'b0;
            link_err <= 1'b0;
        end else begin
            link_err <= 1'b0;
            if (strobe) begin
                unique case (state)
                    ST_COUNT: begin
                        if (marker) begin
                            state   <= ST_LEN;
                            len_cnt <= '0;
                        end else begin
                            last_bit <= s_lvl;
                            idx      <= (idx == LAST) ? '0 : idx + 1'b1;
                        end
                    end
                    ST_LEN: begin
                        len_code <= {len_code[LEN_W-2:0], s_lvl};
                        len_cnt  <= len_cnt + 1'b1;
                        if (len_cnt == CW'(LEN_W - 1)) state <= ST_CLOSE;
                    end
                    ST_CLOSE: begin
                        state <= ST_COUNT;
                        if (marker) idx <= (run_till == LAST) ? '0 : run_till + 1'b1;
                        else        link_err <= 1'b1;
                    end
                    default: state <= ST_COUNT;
                endcase
            end
        end
    end

    // R3: a marker in count mode opens length reception
    a_r3_marker_opens_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && strobe && marker) |=> (state == ST_LEN));

    // R5: an error pulse only follows the close state
    a_r5_err_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |-> ($past(state) == ST_CLOSE && $past(idx) == idx));
endmodule

// File: rtl/rx_cell_bank.sv
// Packet cell register with a from/till range-enable decoder. A single
// write may enable one cell or a contiguous range; all enabled cells take
// the same bit. On completion the merged cells are presented with a pulse.
module rx_cell_bank #(
    parameter int PKT_W = 32,
    parameter int IDX_W = $clog2(PKT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_from,
    input  logic [IDX_W-1:0] wr_till,
    input  logic             wr_bit,
    input  logic             done,
    output logic [PKT_W-1:0] pkt_data,
    output logic             pkt_valid
);
    logic [PKT_W-1:0] cells, cell_en, cells_nx;

    genvar g;
    generate
        for (g = 0; g < PKT_W; g++) begin : g_cell
            // range decode for one cell
            assign cell_en[g]  = wr_en && (IDX_W'(g) >= wr_from) && (IDX_W'(g) <= wr_till);
            assign cells_nx[g] = cell_en[g] ? wr_bit : cells[g];
        end
    endgenerate

    // cell storage and packet hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells     <= '0;
            pkt_data  <= '0;
            pkt_valid <= 1'b0;
        end else begin
            cells     <= cells_nx;
            pkt_valid <= done;
            if (done) pkt_data <= cells_nx;
        end
    end

    // R4: a write enables exactly the cells from..till
    a_r4_range_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(cell_en) == int'(wr_till) - int'(wr_from) + 1));

    // R6: valid lasts one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);
endmodule

// File: rtl/dr_run_rx.sv
// Top: dual-rail run-expanding receiver. Synchronises the two link wires,
// derives strobes and markers, sequences modes and fills the packet cells.
// Assumes the transmitter holds each symbol for at least three clocks.
module dr_run_rx #(
    parameter int PKT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_in,
    input  logic             p_in,
    output logic [PKT_W-1:0] pkt_data,
    output logic             pkt_valid,
    output logic             link_err
);
    localparam int IDX_W = $clog2(PKT_W);
    localparam int LEN_W = $clog2(PKT_W);

    logic [1:0]       lvl, chg;
    logic             strobe, marker;
    logic             wr_en, wr_bit, done;
    logic [IDX_W-1:0] wr_from, wr_till;

    dr_edge_sync #(.NW(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .wire_in({p_in, s_in}),
        .level(lvl), .chg(chg)
    );

    assign strobe = |chg;
    assign marker = &chg;

    rx_seq_ctrl #(.PKT_W(PKT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .marker(marker),
        .s_lvl(lvl[0]), .wr_en(wr_en), .wr_from(wr_from), .wr_till(wr_till),
        .wr_bit(wr_bit), .pkt_done(done), .link_err(link_err)
    );

    rx_cell_bank #(.PKT_W(PKT_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_from(wr_from),
        .wr_till(wr_till), .wr_bit(wr_bit), .done(done),
        .pkt_data(pkt_data), .pkt_valid(pkt_valid)
    );
endmodule

// File: tb/sim_dr_run_rx.sv
module sim_dr_run_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_in = 1'b0;
    logic        p_in = 1'b0;
    logic [31:0] pkt_data;
    logic        pkt_valid, link_err;

    int checks = 0, fails = 0, got_cnt = 0, err_cnt = 0, exp_cnt = 0;
    logic [31:0] got_pkt = '0;

    always #2.5 clk = ~clk;

    dr_run_rx u0 (.clk(clk), .rst_n(rst_n), .s_in(s_in), .p_in(p_in),
                  .pkt_data(pkt_data), .pkt_valid(pkt_valid), .link_err(link_err));

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_valid) begin got_cnt++; got_pkt = pkt_data; end
            if (link_err) err_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        if (b != s_in) s_in = ~s_in; else p_in = ~p_in;
        hold();
    endtask

    task automatic send_marker();
        s_in = ~s_in; p_in = ~p_in;
        hold();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] words [5];
        int ks [5];
        words = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_5555, 32'hF0F0_0FF0, 32'h9E37_79B9};
        ks = '{1, 5, 13, 20, 31};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 pkt_data", pkt_data, 32'h0);
        chk("R7 valid/err", {30'h0, pkt_valid, link_err}, 32'h0);

        // R1 R2 R6: plain packets
        for (int w = 0; w < 5; w++) begin
            for (int i = 0; i < 32; i++) send_bit(words[w][i]);
            exp_cnt++;
            chk("R6 pulse count", 32'(got_cnt), 32'(exp_cnt));
            chk("R2 plain packet", got_pkt, words[w]);
        end

        // R4: runs swept over start position and every length code
        for (int ki = 0; ki < 5; ki++) begin
            for (int code = 0; code < 32; code++) begin
                logic [31:0] src, exp;
                logic [4:0] c5;
                int k, n;
                k   = ks[ki];
                c5  = 5'(code);
                src = 32'h9E37_79B9 * 32'(k * 33 + code + 1);
                exp = src;
                n   = (code + 1 < 32 - k) ? code + 1 : 32 - k;
                for (int i = 0; i < k; i++) send_bit(src[i]);
                send_marker();
                for (int b = 4; b >= 0; b--) send_bit(c5[b]);
                send_marker();
                for (int j = 0; j < n; j++) exp[k + j] = src[k - 1];
                for (int i = k + n; i < 32; i++) send_bit(src[i]);
                exp_cnt++;
                chk("R4 run pulse count", 32'(got_cnt), 32'(exp_cnt));
                chk("R4 run packet", got_pkt, exp);
            end
        end

        // R3 R5: missing closing marker
        begin
            logic [31:0] src;
            src = 32'hC3A5_1E6D;
            for (int i = 0; i < 3; i++) send_bit(src[i]);
            send_marker();
            for (int b = 4; b >= 0; b--) send_bit(1'b1);
            send_bit(~src[2]);
            chk("R5 err pulse", 32'(err_cnt), 32'd1);
            chk("R5 no packet yet", 32'(got_cnt), 32'(exp_cnt));
            for (int i = 3; i < 32; i++) send_bit(src[i]);
            exp_cnt++;
            chk("R5 index kept", got_pkt, src);
            chk("R6 pulse count", 32'(got_cnt), 32'(exp_cnt));
        end

        finish_run();
    end
endmodule